// File: doc/BRIEF.md
# Shared-Buffer Handoff Mutex

This block settles which side may touch a shared capture buffer: the on-chip capture logic or a host computer. The buffer is too small to hold a whole acquisition, so it is filled one chunk at a time. After each chunk the buffer is passed to the host to drain, and then it is returned. Each side owns exactly one flag and can only read the other side's flag. No shared writable arbitration variable exists.

The handover is a four-phase handshake driven by polling. The chip raises its flag once a chunk is complete, and the host answers by raising its flag. The chip then drops its flag, and the host drops its own flag after draining. Only after that does capture resume. The host flag lives in a register that the host writes and reads through a simple register port. Its value crosses into the controller through a synchronizer before the state machine acts on it. A host flag that rises while the chip flag is low breaks the protocol. Such an event is recorded in a sticky error bit and otherwise has no effect.

Top module: `buf_handoff_mutex`

## Requirements
- R1: While reset is active and after it is released, the controller is in its fill state: `buf_en_o`=1, `fpga_flag_o`=0, `proto_err_o`=0, and `host_rd_o`=3'b000.
- R2: A `fill_done_i` sampled high in the fill state makes `fpga_flag_o` go to 1 and `buf_en_o` go to 0 on the next clock edge.
- R3: While `fpga_flag_o` is 1 and the synchronized host flag is 0, `fpga_flag_o` stays 1. `fill_done_i` has no effect in any state other than fill.
- R4: A host write (`host_wr_i`=1) loads `host_wr_flag_i` into the host flag on the next edge. The read word `host_rd_o` carries the host flag in bit 0, the chip flag in bit 1 and the error bit in bit 2.
- R5: The state machine sees a host flag change SYNC_STAGES edges after the host register changes. With the chip flag high, `fpga_flag_o` falls on the edge after that.
- R6: Once the chip flag has dropped, `buf_en_o` stays 0 until the synchronized host flag is seen low. After that comes exactly one more cycle with `buf_en_o`=0, and then `buf_en_o` returns to 1.
- R7: A 0-to-1 change of the synchronized host flag while `fpga_flag_o` is 0 sets `proto_err_o`. The bit stays set until reset, and the event causes no state change.
- R8: `buf_en_o` and `fpga_flag_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr_i | input | 1 | Host write strobe for its own flag |
| host_wr_flag_i | input | 1 | Value written into the host flag |
| host_rd_o | output | 3 | Host read word: {error, chip flag, host flag} |
| fill_done_i | input | 1 | Capture logic reports the current chunk full |
| buf_en_o | output | 1 | Capture logic may write the shared buffer |
| fpga_flag_o | output | 1 | Chip-owned flag: chunk ready for host |
| proto_err_o | output | 1 | Sticky protocol-error status |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default of 2. This lengthens the window between a host write and the controller's reaction. It also makes visible any off-by-one in the synchronizer depth or in the reaction edge. Inside that longer window, the bench covers an early host flag, a host flag raised before the chunk completes, repeated fill-done pulses while waiting, and a sticky error that survives later normal handovers.

// File: rtl/buf_mutex_pkg.sv
package buf_mutex_pkg;

  typedef enum logic [1:0] {
    ST_FILL     = 2'd0,
    ST_WAIT_ACK = 2'd1,
    ST_WAIT_REL = 2'd2,
    ST_RESUME   = 2'd3
  } hand_state_e;

  localparam int unsigned RD_W       = 3;
  localparam int unsigned RD_HOST_IX = 0;
  localparam int unsigned RD_CHIP_IX = 1;
  localparam int unsigned RD_ERR_IX  = 2;

endpackage

// File: rtl/bm_reset_sync.sv
module bm_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/bm_bit_sync.sv
module bm_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/bm_handoff_fsm.sv
module bm_handoff_fsm
  import buf_mutex_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fill_done_i,
  input  logic host_seen_i,
  output logic buf_en_o,
  output logic fpga_flag_o,
  output logic proto_err_o
);

  hand_state_e state_q, state_d;
  logic        seen_prev_q;
  logic        err_q, err_d;
  logic        host_rise;

  assign host_rise = host_seen_i & ~seen_prev_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FILL:     if (fill_done_i)  state_d = ST_WAIT_ACK;
      ST_WAIT_ACK: if (host_seen_i)  state_d = ST_WAIT_REL;
      ST_WAIT_REL: if (!host_seen_i) state_d = ST_RESUME;
      ST_RESUME:                     state_d = ST_FILL;
      default:                       state_d = ST_FILL;
    endcase
  end

  always_comb begin
    err_d = err_q;
    if (host_rise && (state_q != ST_WAIT_ACK)) err_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_FILL;
      seen_prev_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      seen_prev_q <= host_seen_i;
      err_q       <= err_d;
    end
  end

  assign buf_en_o    = (state_q == ST_FILL);
  assign fpga_flag_o = (state_q == ST_WAIT_ACK);
  assign proto_err_o = err_q;

  assert_fill_done_raises_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_en_o && fill_done_i) |=> (fpga_flag_o && !buf_en_o));

  assert_flag_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fpga_flag_o && !host_seen_i) |=> fpga_flag_o);

  assert_release_no_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fpga_flag_o && host_seen_i) |=> (!fpga_flag_o && !buf_en_o));

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);

  assert_err_no_move_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_en_o && !fill_done_i && host_rise) |=> (buf_en_o && proto_err_o));

  assert_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(buf_en_o && fpga_flag_o));

endmodule

// File: rtl/buf_handoff_mutex.sv
module buf_handoff_mutex
  import buf_mutex_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned RESET_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            host_wr_i,
  input  logic            host_wr_flag_i,
  output logic [RD_W-1:0] host_rd_o,
  input  logic            fill_done_i,
  output logic            buf_en_o,
  output logic            fpga_flag_o,
  output logic            proto_err_o
);

  logic rst_n;
  logic host_flag_q, host_flag_d;
  logic host_seen;

  bm_reset_sync #(.STAGES(RESET_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  always_comb begin
    host_flag_d = host_flag_q;
    if (host_wr_i) host_flag_d = host_wr_flag_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) host_flag_q <= 1'b0;
    else        host_flag_q <= host_flag_d;
  end

  bm_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    (host_flag_q),
    .q_o    (host_seen)
  );

  bm_handoff_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .fill_done_i (fill_done_i),
    .host_seen_i (host_seen),
    .buf_en_o    (buf_en_o),
    .fpga_flag_o (fpga_flag_o),
    .proto_err_o (proto_err_o)
  );

  always_comb begin
    host_rd_o             = '0;
    host_rd_o[RD_HOST_IX] = host_flag_q;
    host_rd_o[RD_CHIP_IX] = fpga_flag_o;
    host_rd_o[RD_ERR_IX]  = proto_err_o;
  end

  assert_host_write_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    host_wr_i |=> (host_rd_o[RD_HOST_IX] == $past(host_wr_flag_i)));

endmodule

// File: tb/buf_handoff_mutex_tb_top.sv
module buf_handoff_mutex_tb_top;

  localparam int SYNC = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, wr_flag = 1'b0, fill_done = 1'b0;
  logic [2:0] rd;
  logic       buf_en, fflag, perr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  buf_handoff_mutex #(.SYNC_STAGES(SYNC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(wr), .host_wr_flag_i(wr_flag),
    .host_rd_o(rd), .fill_done_i(fill_done), .buf_en_o(buf_en),
    .fpga_flag_o(fflag), .proto_err_o(perr));

  // Reference model. States: 0 fill, 1 waiting for host, 2 waiting for host release, 3 resume.
  int m_state = 0, m_rcnt = 0;
  bit m_hflag = 0, m_err = 0, m_prev = 0;
  bit m_pipe[$];

  initial for (int i = 0; i < SYNC; i++) m_pipe.push_back(1'b0);

  always @(posedge clk) begin
    bit seen;
    int nstate;
    if (!rst_n || m_rcnt < 2) begin
      if (!rst_n) m_rcnt = 0; else m_rcnt++;
      m_state = 0; m_hflag = 0; m_err = 0; m_prev = 0;
      for (int i = 0; i < SYNC; i++) m_pipe[i] = 1'b0;
    end else begin
      seen = m_pipe[SYNC-1];
      nstate = m_state;
      case (m_state)
        0: if (fill_done) nstate = 1;
        1: if (seen) nstate = 2;
        2: if (!seen) nstate = 3;
        default: nstate = 0;
      endcase
      if (seen && !m_prev && m_state != 1) m_err = 1;
      m_prev = seen;
      m_pipe.push_front(m_hflag);
      void'(m_pipe.pop_back());
      if (wr) m_hflag = wr_flag;
      m_state = nstate;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && m_rcnt >= 2) begin
    check("R6 buf_en", buf_en, m_state == 0);
    check("R2 fpga_flag", fflag, m_state == 1);
    check("R7 proto_err", perr, m_err);
    check("R4 host_rd", rd, {m_err, m_state == 1, m_hflag});
    check("R8 exclusive", buf_en & fflag, 0);
  end

  task automatic host_write(bit v);
    @(negedge clk); wr = 1'b1; wr_flag = v;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); fill_done = 1'b1;
    @(negedge clk); fill_done = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    // R1: values during reset
    check("R1 buf_en in reset", buf_en, 1);
    check("R1 flag in reset", fflag, 0);
    check("R1 err in reset", perr, 0);
    check("R1 rd in reset", rd, 0);
    rst_n = 1'b1;
    idle(4);
    check("R1 buf_en after reset", buf_en, 1);
    check("R1 rd after reset", rd, 0);

    // R2 / R3: chunk done, host silent; extra fill_done ignored
    pulse_done();
    check("R2 flag raised", fflag, 1);
    check("R2 buffer stopped", buf_en, 0);
    pulse_done();
    idle(6);
    check("R3 flag held", fflag, 1);

    // R5: host acknowledges; reaction after SYNC+1 edges
    host_write(1'b1);
    check("R4 host flag read", rd[0], 1);
    idle(SYNC);
    check("R5 flag before sync latency", fflag, 1);
    idle(1);
    check("R5 flag dropped", fflag, 0);
    check("R6 no capture while host holds", buf_en, 0);
    idle(5);
    check("R6 still no capture", buf_en, 0);
    host_write(1'b0);
    idle(SYNC + 1);
    check("R6 resume gap", buf_en, 0);
    idle(1);
    check("R6 capture back", buf_en, 1);
    check("R7 no error on clean handover", perr, 0);

    // R7: host raises flag while chip flag low
    host_write(1'b1);
    idle(SYNC + 2);
    check("R7 error latched", perr, 1);
    check("R7 state unchanged", buf_en, 1);
    host_write(1'b0);
    idle(SYNC + 2);
    check("R7 error sticky", rd[2], 1);

    // Host flag already high when chunk completes: immediate release
    host_write(1'b1);
    idle(SYNC + 2);
    pulse_done();
    check("R2 early ack raise", fflag, 1);
    idle(1);
    check("R6 early ack release", fflag, 0);
    host_write(1'b0);
    idle(SYNC + 3);
    check("R6 back to fill", buf_en, 1);

    // Second normal handover with error still set
    pulse_done();
    host_write(1'b1);
    idle(SYNC + 2);
    host_write(1'b0);
    idle(SYNC + 4);
    check("R6 fill after second round", buf_en, 1);
    check("R7 error kept", perr, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule